// File: doc/BRIEF.md
# Branch Resolution Unit

This block resolves branch instructions for a 32-bit core whose instruction words number their bits from the most significant end. The most significant bit is bit 0. Each cycle that `valid_i` is high it takes an instruction word, the address of that instruction, the 32-bit condition register and the current link and count register values. One cycle later it reports four things:

- whether the branch is taken;
- the address to fetch next;
- new link and count register values, each with its own write enable;
- a flag for an illegal branch encoding.

Four forms are recognised:

- an unconditional immediate form;
- a conditional immediate form;
- a conditional jump to the link register;
- a conditional jump to the count register.

A conditional branch tests one selectable condition-register bit against a required value. It can also decrement the count register and test the result for zero or non-zero. Any branch may save its return address in the link register. A word that is not one of these forms passes through with no effect, so the surrounding core can feed every instruction to the unit.

Top module: `br_eval_unit`

## Requirements
- R1: An instruction whose primary opcode (the top six bits, insn[31:26]) equals 18 is an unconditional branch. It is always taken. Its 24-bit displacement sits in insn[25:2]. The target is the branch address plus the displacement shifted left by two and sign-extended.
- R2: The absolute flag is insn[1], in both immediate forms. When it is 1, the target is the shifted, sign-extended displacement on its own, and the branch address is not added.
- R3: Opcode 16 is the conditional immediate form. Its fields are:
  - control field: insn[25:21];
  - condition-bit selector S: insn[20:16];
  - 14-bit displacement: insn[15:2].
  Selector S picks condition-register bit S counted from the most significant end, i.e. cr_i[31-S]. If control-field bit 4 (insn[25]) is 1, the condition test always passes. Otherwise the test passes when the selected bit equals control-field bit 3 (insn[24]). Control-field bit 0 has no effect.
- R4: In every conditional form, control-field bit 2 (insn[23]) = 0 asks for a count decrement. The decremented count is written back with `ctr_we_o`. The count test then passes when (new count == 0) equals control-field bit 1 (insn[22]). When no decrement is asked for, the count test always passes.
- R5: A conditional immediate branch is taken only when both the condition test and the count test pass. When it is not taken, the target is the branch address + 4, wrapping at the address width.
- R6: When the link flag insn[0] is 1 on any recognised legal branch, the link register is written with the branch address + 4. This happens whether or not the branch is taken.
- R7: Opcode 19 with extended code 16 in insn[10:1] jumps to the link register with its two low bits cleared. It uses the same condition and count rules as R3 and R4. When the link flag is also set, the target is the link value from before the write.
- R8: Opcode 19 with extended code 528 in insn[10:1] jumps to the count register with its two low bits cleared. It is taken when the condition test of R3 passes. The count register is not written.
- R9: The count-register form with a decrement request (insn[23] = 0) is illegal. `illegal_o` rises, the branch is not taken, and neither register is written.
- R10: Any other opcode, and opcode 19 with any other extended code, is not a branch. The result is not taken, with no writes, no illegal flag, and a target of the branch address + 4.
- R11: Results appear on the clock edge after `valid_i` is sampled high, with `res_valid_o` set. In a cycle with no result, and after reset, the taken flag, both write enables, the illegal flag and the value outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| insn_i | input | 32 | Instruction word |
| pc_i | input | ADDR_W | Address of the instruction |
| cr_i | input | 32 | Condition register |
| lr_i | input | ADDR_W | Current link register |
| ctr_i | input | ADDR_W | Current count register |
| res_valid_o | output | 1 | A result is present |
| taken_o | output | 1 | Branch taken |
| target_o | output | ADDR_W | Next fetch address |
| lr_we_o | output | 1 | Link register write enable |
| lr_o | output | ADDR_W | New link register value |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_o | output | ADDR_W | New count register value |
| illegal_o | output | 1 | Illegal branch encoding |

## Verification
The bench builds the unit with its default parameters: a 32-bit address width and the default opcode and extended-code values. With a full 32-bit address, both wrap cases come within reach. One is the fall-through address wrapping from 0xFFFFFFFC to 0. The other is a count of zero decrementing to all ones. The negative 24-bit displacement edge also lands on a distinct upper-address pattern, 0xFE000000. Because the extended codes use their default values, the bench can reach the link form, the count form, the illegal count form with a decrement request, and an unrelated opcode-19 word.

// File: rtl/br_pkg.sv
package br_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned CR_W   = 32;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned CTL_W  = 5;
  localparam int unsigned SEL_W  = 5;
  localparam int unsigned XO_W   = 10;
  localparam int unsigned LDSP_W = 24;
  localparam int unsigned SDSP_W = 14;

  typedef enum logic [2:0] {
    FORM_NONE      = 3'd0,
    FORM_IMM_JUMP  = 3'd1,
    FORM_IMM_COND  = 3'd2,
    FORM_REG_LINK  = 3'd3,
    FORM_REG_COUNT = 3'd4
  } br_form_e;

  typedef struct packed {
    br_form_e            form;
    logic [CTL_W-1:0]    ctl;
    logic [SEL_W-1:0]    sel;
    logic [LDSP_W-1:0]   disp;
    logic                absolute;
    logic                link;
  } br_fields_t;

  // control-field bit meanings (value bit positions, LSB = 0)
  localparam int unsigned CTL_NO_COND = 4;
  localparam int unsigned CTL_WANT    = 3;
  localparam int unsigned CTL_NO_DEC  = 2;
  localparam int unsigned CTL_ON_ZERO = 1;

endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
#(
  parameter int unsigned OPC_JUMP  = 18,
  parameter int unsigned OPC_COND  = 16,
  parameter int unsigned OPC_REG   = 19,
  parameter int unsigned XO_LINK   = 16,
  parameter int unsigned XO_COUNT  = 528
) (
  input  logic [INSN_W-1:0] insn,
  output br_fields_t        fields
);

  // big-endian bit b of the word is little-endian bit (INSN_W-1-b)
  logic [OPC_W-1:0]  opc;
  logic [CTL_W-1:0]  ctl;
  logic [SEL_W-1:0]  sel;
  logic [SDSP_W-1:0] short_disp;
  logic [LDSP_W-1:0] long_disp;
  logic [XO_W-1:0]   xo;
  logic              aa_bit;
  logic              lk_bit;

  assign opc        = insn[31:26];
  assign ctl        = insn[25:21];
  assign sel        = insn[20:16];
  assign short_disp = insn[15:2];
  assign long_disp  = insn[25:2];
  assign xo         = insn[10:1];
  assign aa_bit     = insn[1];
  assign lk_bit     = insn[0];

  function automatic logic [LDSP_W-1:0] widen_short(input logic [SDSP_W-1:0] d);
    return {{(LDSP_W-SDSP_W){d[SDSP_W-1]}}, d};
  endfunction

  function automatic br_form_e classify(input logic [OPC_W-1:0] o, input logic [XO_W-1:0] x);
    br_form_e f;
    f = FORM_NONE;
    if (o == OPC_W'(OPC_JUMP))      f = FORM_IMM_JUMP;
    else if (o == OPC_W'(OPC_COND)) f = FORM_IMM_COND;
    else if (o == OPC_W'(OPC_REG)) begin
      if (x == XO_W'(XO_LINK))       f = FORM_REG_LINK;
      else if (x == XO_W'(XO_COUNT)) f = FORM_REG_COUNT;
    end
    return f;
  endfunction

  always_comb begin
    fields          = '0;
    fields.form     = classify(opc, xo);
    fields.ctl      = ctl;
    fields.sel      = sel;
    fields.link     = lk_bit;
    unique case (fields.form)
      FORM_IMM_JUMP: begin
        fields.disp     = long_disp;
        fields.absolute = aa_bit;
      end
      FORM_IMM_COND: begin
        fields.disp     = widen_short(short_disp);
        fields.absolute = aa_bit;
      end
      default: begin
        fields.disp     = '0;
        fields.absolute = 1'b0;
      end
    endcase
    if (fields.form == FORM_NONE) fields.link = 1'b0;
  end

endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  br_fields_t        fields,
  input  logic [CR_W-1:0]   cr,
  input  logic [ADDR_W-1:0] ctr,
  output logic              cond_ok,
  output logic              count_ok,
  output logic              dec_req,
  output logic [ADDR_W-1:0] ctr_next,
  output logic              illegal,
  output logic              go,
  output logic              lr_we,
  output logic              ctr_we
);

  logic sel_bit;
  logic is_cond_form;

  function automatic logic pick_cr_bit(input logic [CR_W-1:0] c, input logic [SEL_W-1:0] s);
    // selector counts from the most significant bit
    return c[(CR_W-1) - int'(s)];
  endfunction

  function automatic logic [ADDR_W-1:0] step_down(input logic [ADDR_W-1:0] v);
    return v - ADDR_W'(1);
  endfunction

  assign is_cond_form = (fields.form == FORM_IMM_COND) ||
                        (fields.form == FORM_REG_LINK) ||
                        (fields.form == FORM_REG_COUNT);

  assign sel_bit  = pick_cr_bit(cr, fields.sel);
  assign cond_ok  = fields.ctl[CTL_NO_COND] || (sel_bit == fields.ctl[CTL_WANT]);
  assign dec_req  = is_cond_form && !fields.ctl[CTL_NO_DEC];
  assign ctr_next = step_down(ctr);
  assign count_ok = !dec_req || ((ctr_next == '0) == fields.ctl[CTL_ON_ZERO]);
  assign illegal  = (fields.form == FORM_REG_COUNT) && dec_req;

  always_comb begin
    go = 1'b0;
    unique case (fields.form)
      FORM_IMM_JUMP:  go = 1'b1;
      FORM_IMM_COND,
      FORM_REG_LINK:  go = cond_ok && count_ok;
      FORM_REG_COUNT: go = cond_ok && !illegal;
      default:        go = 1'b0;
    endcase
  end

  assign ctr_we = dec_req && !illegal;
  assign lr_we  = fields.link && (fields.form != FORM_NONE) && !illegal;

endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  br_fields_t        fields,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] lr,
  input  logic [ADDR_W-1:0] ctr,
  input  logic              go,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] jump_addr,
  output logic [ADDR_W-1:0] next_addr
);

  localparam int unsigned OFF_W = LDSP_W + 2;

  function automatic logic [ADDR_W-1:0] word_offset(input logic [LDSP_W-1:0] d);
    return {{(ADDR_W-OFF_W){d[LDSP_W-1]}}, d, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] v);
    return {v[ADDR_W-1:2], 2'b00};
  endfunction

  logic [ADDR_W-1:0] offset;

  assign offset   = word_offset(fields.disp);
  assign seq_addr = pc + ADDR_W'(4);

  always_comb begin
    unique case (fields.form)
      FORM_IMM_JUMP,
      FORM_IMM_COND:  jump_addr = fields.absolute ? offset : (pc + offset);
      FORM_REG_LINK:  jump_addr = word_align(lr);
      FORM_REG_COUNT: jump_addr = word_align(ctr);
      default:        jump_addr = seq_addr;
    endcase
  end

  assign next_addr = go ? jump_addr : seq_addr;

endmodule

// File: rtl/br_eval_unit.sv
module br_eval_unit
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OPC_JUMP = 18,
  parameter int unsigned OPC_COND = 16,
  parameter int unsigned OPC_REG  = 19,
  parameter int unsigned XO_LINK  = 16,
  parameter int unsigned XO_COUNT = 528
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [31:0]       cr_i,
  input  logic [ADDR_W-1:0] lr_i,
  input  logic [ADDR_W-1:0] ctr_i,
  output logic              res_valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              lr_we_o,
  output logic [ADDR_W-1:0] lr_o,
  output logic              ctr_we_o,
  output logic [ADDR_W-1:0] ctr_o,
  output logic              illegal_o
);

  br_fields_t        dec_fields;
  br_form_e          dec_form;
  logic              ev_cond_ok;
  logic              ev_count_ok;
  logic              ev_dec_req;
  logic [ADDR_W-1:0] ev_ctr_next;
  logic              ev_illegal;
  logic              ev_go;
  logic              ev_lr_we;
  logic              ev_ctr_we;
  logic [ADDR_W-1:0] ev_seq;
  logic [ADDR_W-1:0] ev_jump;
  logic [ADDR_W-1:0] ev_next;

  br_decode #(
    .OPC_JUMP (OPC_JUMP),
    .OPC_COND (OPC_COND),
    .OPC_REG  (OPC_REG),
    .XO_LINK  (XO_LINK),
    .XO_COUNT (XO_COUNT)
  ) u_decode (
    .insn   (insn_i),
    .fields (dec_fields)
  );

  assign dec_form = dec_fields.form;

  br_cond #(.ADDR_W(ADDR_W)) u_cond (
    .fields   (dec_fields),
    .cr       (cr_i),
    .ctr      (ctr_i),
    .cond_ok  (ev_cond_ok),
    .count_ok (ev_count_ok),
    .dec_req  (ev_dec_req),
    .ctr_next (ev_ctr_next),
    .illegal  (ev_illegal),
    .go       (ev_go),
    .lr_we    (ev_lr_we),
    .ctr_we   (ev_ctr_we)
  );

  br_target #(.ADDR_W(ADDR_W)) u_target (
    .fields    (dec_fields),
    .pc        (pc_i),
    .lr        (lr_i),
    .ctr       (ctr_i),
    .go        (ev_go),
    .seq_addr  (ev_seq),
    .jump_addr (ev_jump),
    .next_addr (ev_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !valid_i) begin
      res_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      target_o    <= '0;
      lr_we_o     <= 1'b0;
      lr_o        <= '0;
      ctr_we_o    <= 1'b0;
      ctr_o       <= '0;
      illegal_o   <= 1'b0;
    end else begin
      res_valid_o <= 1'b1;
      taken_o     <= ev_go;
      target_o    <= ev_next;
      lr_we_o     <= ev_lr_we;
      lr_o        <= ev_lr_we ? ev_seq : '0;
      ctr_we_o    <= ev_ctr_we;
      ctr_o       <= ev_ctr_we ? ev_ctr_next : '0;
      illegal_o   <= ev_illegal;
    end
  end

endmodule

// File: rtl/br_eval_checker.sv
module br_eval_checker
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] lr_i,
  input logic [ADDR_W-1:0] ctr_i,
  input br_form_e          dec_form,
  input logic              res_valid_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] target_o,
  input logic              lr_we_o,
  input logic [ADDR_W-1:0] lr_o,
  input logic              ctr_we_o,
  input logic [ADDR_W-1:0] ctr_o,
  input logic              illegal_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] LOW2 = ADDR_W'(3);

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> !(taken_o || lr_we_o || ctr_we_o || illegal_o));

  p_result_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> res_valid_o);

  p_illegal_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!taken_o && !lr_we_o && !ctr_we_o));

  p_link_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we_o |-> (lr_o == $past(pc_i) + STEP));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_we_o |-> (ctr_o == $past(ctr_i) - ADDR_W'(1)));

  p_fallthrough_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !taken_o) |-> (target_o == $past(pc_i) + STEP));

  p_jump_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dec_form == FORM_IMM_JUMP) |=> taken_o);

  p_link_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dec_form == FORM_REG_LINK) |=>
      (!taken_o || target_o == ($past(lr_i) & ~LOW2)));

  p_count_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dec_form == FORM_REG_COUNT) |=>
      (!ctr_we_o && (!taken_o || target_o == ($past(ctr_i) & ~LOW2))));

  p_non_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dec_form == FORM_NONE) |=>
      (!taken_o && !lr_we_o && !ctr_we_o && !illegal_o));

endmodule

bind br_eval_unit br_eval_checker #(.ADDR_W(ADDR_W)) u_br_eval_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .pc_i        (pc_i),
  .lr_i        (lr_i),
  .ctr_i       (ctr_i),
  .dec_form    (dec_form),
  .res_valid_o (res_valid_o),
  .taken_o     (taken_o),
  .target_o    (target_o),
  .lr_we_o     (lr_we_o),
  .lr_o        (lr_o),
  .ctr_we_o    (ctr_we_o),
  .ctr_o       (ctr_o),
  .illegal_o   (illegal_o)
);

// File: tb/test_br_eval_unit.sv
module test_br_eval_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [31:0] insn_i;
  logic [31:0] pc_i;
  logic [31:0] cr_i;
  logic [31:0] lr_i;
  logic [31:0] ctr_i;
  logic        res_valid_o;
  logic        taken_o;
  logic [31:0] target_o;
  logic        lr_we_o;
  logic [31:0] lr_o;
  logic        ctr_we_o;
  logic [31:0] ctr_o;
  logic        illegal_o;

  int checks;
  int errors;
  bit done;

  br_eval_unit i_br_eval_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .insn_i      (insn_i),
    .pc_i        (pc_i),
    .cr_i        (cr_i),
    .lr_i        (lr_i),
    .ctr_i       (ctr_i),
    .res_valid_o (res_valid_o),
    .taken_o     (taken_o),
    .target_o    (target_o),
    .lr_we_o     (lr_we_o),
    .lr_o        (lr_o),
    .ctr_we_o    (ctr_we_o),
    .ctr_o       (ctr_o),
    .illegal_o   (illegal_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_jump(input logic [23:0] d, input logic aa, input logic lk);
    return {6'd18, d, aa, lk};
  endfunction

  function automatic logic [31:0] mk_cond(input logic [4:0] ctl, input logic [4:0] s,
                                          input logic [13:0] d, input logic aa, input logic lk);
    return {6'd16, ctl, s, d, aa, lk};
  endfunction

  function automatic logic [31:0] mk_reg(input logic [4:0] ctl, input logic [4:0] s,
                                         input logic [9:0] xo, input logic lk);
    return {6'd19, ctl, s, 5'd0, xo, lk};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] insn, input logic [31:0] pc, input logic [31:0] cr,
                       input logic [31:0] lr, input logic [31:0] ctr);
    @(negedge clk);
    valid_i = 1'b1;
    insn_i  = insn;
    pc_i    = pc;
    cr_i    = cr;
    lr_i    = lr;
    ctr_i   = ctr;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // full result comparison; lr_o / ctr_o compared only when their enable is expected
  task automatic expect_res(input string tag, input logic tk, input logic [31:0] tgt,
                            input logic lwe, input logic [31:0] lv,
                            input logic cwe, input logic [31:0] cv, input logic ill);
    chk({tag, " valid"},   32'(res_valid_o), 32'd1);
    chk({tag, " taken"},   32'(taken_o), 32'(tk));
    chk({tag, " target"},  target_o, tgt);
    chk({tag, " lr_we"},   32'(lr_we_o), 32'(lwe));
    if (lwe) chk({tag, " lr"}, lr_o, lv);
    chk({tag, " ctr_we"},  32'(ctr_we_o), 32'(cwe));
    if (cwe) chk({tag, " ctr"}, ctr_o, cv);
    chk({tag, " illegal"}, 32'(illegal_o), 32'(ill));
  endtask

  task automatic t_reset;
    chk("R11 reset valid",   32'(res_valid_o), 32'd0);
    chk("R11 reset taken",   32'(taken_o), 32'd0);
    chk("R11 reset target",  target_o, 32'd0);
    chk("R11 reset lr_we",   32'(lr_we_o), 32'd0);
    chk("R11 reset ctr_we",  32'(ctr_we_o), 32'd0);
    chk("R11 reset illegal", 32'(illegal_o), 32'd0);
  endtask

  task automatic t_uncond;
    issue(mk_jump(24'h000010, 1'b0, 1'b0), 32'h0000_1000, 32'h0, 32'h0, 32'h0);
    expect_res("R1 fwd", 1, 32'h0000_1040, 0, 0, 0, 0, 0);
    issue(mk_jump(24'hFFFFFF, 1'b0, 1'b1), 32'h0000_1000, 32'h0, 32'h0, 32'h0);
    expect_res("R1 back + R6 link", 1, 32'h0000_0FFC, 1, 32'h0000_1004, 0, 0, 0);
  endtask

  task automatic t_absolute;
    issue(mk_jump(24'h000100, 1'b1, 1'b0), 32'h0000_8000, 32'h0, 32'h0, 32'h0);
    expect_res("R2 abs pos", 1, 32'h0000_0400, 0, 0, 0, 0, 0);
    issue(mk_jump(24'h800000, 1'b1, 1'b0), 32'h0000_8000, 32'h0, 32'h0, 32'h0);
    expect_res("R2 abs neg", 1, 32'hFE00_0000, 0, 0, 0, 0, 0);
    issue(mk_cond(5'b10100, 5'd0, 14'h0040, 1'b1, 1'b0), 32'h0000_7000, 32'h0, 32'h0, 32'h0);
    expect_res("R2 cond abs", 1, 32'h0000_0100, 0, 0, 0, 0, 0);
  endtask

  task automatic t_condition;
    issue(mk_cond(5'b01100, 5'd2, 14'h0010, 1'b0, 1'b0), 32'h0000_2000, 32'h2000_0000, 0, 0);
    expect_res("R3 bit2 set want1", 1, 32'h0000_2040, 0, 0, 0, 0, 0);
    issue(mk_cond(5'b01100, 5'd2, 14'h0010, 1'b0, 1'b0), 32'h0000_2000, 32'hDFFF_FFFF, 0, 0);
    expect_res("R3 bit2 clear want1", 0, 32'h0000_2004, 0, 0, 0, 0, 0);
    issue(mk_cond(5'b00100, 5'd31, 14'h0010, 1'b0, 1'b0), 32'h0000_2000, 32'h0000_0001, 0, 0);
    expect_res("R3 bit31 set want0", 0, 32'h0000_2004, 0, 0, 0, 0, 0);
    issue(mk_cond(5'b00100, 5'd31, 14'h0010, 1'b0, 1'b0), 32'h0000_2000, 32'hFFFF_FFFE, 0, 0);
    expect_res("R3 bit31 clear want0", 1, 32'h0000_2040, 0, 0, 0, 0, 0);
    issue(mk_cond(5'b10100, 5'd0, 14'h3FFF, 1'b0, 1'b0), 32'h0000_0100, 32'h0, 0, 0);
    expect_res("R3 always back", 1, 32'h0000_00FC, 0, 0, 0, 0, 0);
    issue(mk_cond(5'b10101, 5'd0, 14'h3FFF, 1'b0, 1'b0), 32'h0000_0100, 32'h0, 0, 0);
    expect_res("R3 ctl bit0 ignored", 1, 32'h0000_00FC, 0, 0, 0, 0, 0);
  endtask

  task automatic t_count;
    issue(mk_cond(5'b10000, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h0000_0300, 0, 0, 32'd5);
    expect_res("R4 dec nonzero", 1, 32'h0000_0320, 0, 0, 1, 32'd4, 0);
    issue(mk_cond(5'b10000, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h0000_0300, 0, 0, 32'd1);
    expect_res("R4 dec hits zero", 0, 32'h0000_0304, 0, 0, 1, 32'd0, 0);
    issue(mk_cond(5'b10010, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h0000_0300, 0, 0, 32'd1);
    expect_res("R4 dec want zero", 1, 32'h0000_0320, 0, 0, 1, 32'd0, 0);
    issue(mk_cond(5'b10000, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h0000_0300, 0, 0, 32'd0);
    expect_res("R4 dec wraps", 1, 32'h0000_0320, 0, 0, 1, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_combined;
    issue(mk_cond(5'b01000, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h0000_0300, 32'h8000_0000, 0, 32'd1);
    expect_res("R5 cond ok count fails", 0, 32'h0000_0304, 0, 0, 1, 32'd0, 0);
    issue(mk_cond(5'b01000, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h0000_0300, 32'h8000_0000, 0, 32'd2);
    expect_res("R5 both pass", 1, 32'h0000_0320, 0, 0, 1, 32'd1, 0);
    issue(mk_cond(5'b01000, 5'd0, 14'h0008, 1'b0, 1'b0), 32'h0000_0300, 32'h0, 0, 32'd2);
    expect_res("R5 count ok cond fails", 0, 32'h0000_0304, 0, 0, 1, 32'd1, 0);
    issue(mk_cond(5'b01100, 5'd0, 14'h0008, 1'b0, 1'b0), 32'hFFFF_FFFC, 32'h0, 0, 0);
    expect_res("R5 fallthrough wraps", 0, 32'h0000_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_link_not_taken;
    issue(mk_cond(5'b01100, 5'd0, 14'h0008, 1'b0, 1'b1), 32'h0000_0040, 32'h0, 0, 0);
    expect_res("R6 link on not taken", 0, 32'h0000_0044, 1, 32'h0000_0044, 0, 0, 0);
  endtask

  task automatic t_reg_link;
    issue(mk_reg(5'b10100, 5'd0, 10'd16, 1'b1), 32'h0000_0500, 0, 32'h0000_2003, 0);
    expect_res("R7 to link old value", 1, 32'h0000_2000, 1, 32'h0000_0504, 0, 0, 0);
    issue(mk_reg(5'b10000, 5'd0, 10'd16, 1'b0), 32'h0000_0500, 0, 32'h0000_0600, 32'd3);
    expect_res("R7 to link with dec", 1, 32'h0000_0600, 0, 0, 1, 32'd2, 0);
  endtask

  task automatic t_reg_count;
    issue(mk_reg(5'b10100, 5'd0, 10'd528, 1'b0), 32'h0000_0500, 0, 0, 32'h0000_3007);
    expect_res("R8 to count", 1, 32'h0000_3004, 0, 0, 0, 0, 0);
    issue(mk_reg(5'b01100, 5'd0, 10'd528, 1'b1), 32'h0000_0500, 32'h0, 0, 32'h0000_3007);
    expect_res("R8 count cond fails", 0, 32'h0000_0504, 1, 32'h0000_0504, 0, 0, 0);
  endtask

  task automatic t_illegal;
    issue(mk_reg(5'b10000, 5'd0, 10'd528, 1'b1), 32'h0000_0700, 0, 0, 32'd9);
    expect_res("R9 count form decrement", 0, 32'h0000_0704, 0, 0, 0, 0, 1);
  endtask

  task automatic t_non_branch;
    issue({6'd31, 26'h3FF_FFFF}, 32'h0000_0800, 32'hFFFF_FFFF, 32'h1234, 32'd4);
    expect_res("R10 other opcode", 0, 32'h0000_0804, 0, 0, 0, 0, 0);
    issue(mk_reg(5'b10100, 5'd0, 10'd150, 1'b1), 32'h0000_0800, 0, 32'h1234, 32'd4);
    expect_res("R10 other extended code", 0, 32'h0000_0804, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    valid_i = 1'b0;
    insn_i  = mk_jump(24'h000001, 1'b0, 1'b1);
    @(negedge clk);
    chk("R11 idle valid", 32'(res_valid_o), 32'd0);
    chk("R11 idle taken", 32'(taken_o), 32'd0);
    chk("R11 idle lr_we", 32'(lr_we_o), 32'd0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; valid_i = 1'b0;
    insn_i = '0; pc_i = '0; cr_i = '0; lr_i = '0; ctr_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_uncond();
    t_absolute();
    t_condition();
    t_count();
    t_combined();
    t_link_not_taken();
    t_reg_link();
    t_reg_count();
    t_illegal();
    t_non_branch();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule